// File: doc/BRIEF.md
# Sixteen-Bit Up/Down Event Timer

This block is a general-purpose 16-bit timer that a processor controls through a 32-bit register port. Software picks a power-of-two prescale, a clock source, a count direction and an optional one-shot behaviour. It starts and stops the counter with a command word and can read or load the count at any time. A reload value sets the wrap point in both directions.

When an up count passes its reload value, or a down count passes zero, the timer raises an event flag. Each flag has an enable bit. Software can set or clear a flag through two separate write addresses. The enabled flags are ORed onto one registered interrupt line. To arm a single timed event, software issues stop, loads the count, then issues start. In one-shot mode the timer halts on its own when the event fires.

Top module: `gp_evtimer`

## Requirements
- R1: After reset, the control word, count, flags and enables all read 0. The reload value reads 0xFFFF and the interrupt output is low.
- R2: Register offsets are: control 0x00, command 0x04, enable 0x0C, flags 0x10, flag-set 0x14, flag-clear 0x18, reload 0x1C, count 0x24. The control word keeps only these fields: bits 27:24 (prescale exponent), bits 17:16 (clock source), bit 4 (one-shot) and bits 1:0 (mode). Enable keeps bits 1:0. Command and unmapped offsets read 0. Read data appears on the clock edge that follows the read request.
- R3: Writing command bit 0 starts the counter and writing command bit 1 stops it. If both bits are set in one write, stop wins.
- R4: With prescale exponent N, a running timer advances once every 2^N clocks. The first advance comes 2^N clocks after the edge that accepts the start command, and every start command restarts the prescale phase.
- R5: In mode 0 (up), an advance at count equal to the reload value wraps the count to 0 and sets flag bit 0 (overflow). Any other advance adds one.
- R6: In mode 1 (down), an advance at count 0 loads the reload value and sets flag bit 1 (underflow). Any other advance subtracts one.
- R7: With one-shot set (control bit 4), the timer stops on the advance that raises an overflow or underflow. It keeps the count it wrapped or reloaded to.
- R8: A count write takes effect on the next edge. A stopped timer holds its count.
- R9: Writing 1s to flag-set sets those flags and writing 1s to flag-clear clears them. If a hardware event and a clear hit the same flag on the same edge, the flag ends set.
- R10: Writes to the flags offset itself change no flag.
- R11: The interrupt output is the OR over all bits of (flags AND enables), registered one clock after the flags. It stays high until the flag is cleared or its enable is dropped.
- R12: A clock source value other than 0 produces no advances, so a started timer holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions watch several properties on every cycle. A tick at a nonzero prescale is never followed directly by another tick. The up count wraps to zero at the reload value, and the down count reloads at zero. A one-shot event halts the run. A stopped counter with no load holds its value. A clear with no concurrent set empties the cleared flags. The bench covers what depends on command ordering or absolute cycle counts. It sweeps prescale exponents, both directions and stop points, and compares the count and flags with an arithmetic model. It also checks the restart of the prescale phase, stop priority, the same-edge race between a hardware event and a clear, ignored flag writes, the one-cycle lag of the interrupt, and the non-counting clock source.

// File: rtl/gp_evtimer_pkg.sv
package gp_evtimer_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_FLAGS = 8'h10;
  localparam logic [7:0] OFS_FSET  = 8'h14;
  localparam logic [7:0] OFS_FCLR  = 8'h18;
  localparam logic [7:0] OFS_RELD  = 8'h1C;
  localparam logic [7:0] OFS_COUNT = 8'h24;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_UNF  = 1;

  typedef struct packed {
    logic [3:0] exp;
    logic [1:0] src;
    logic       oneshot;
    logic [1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/gp_evtimer_presc.sv
module gp_evtimer_presc #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(exp)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) div_q <= '0;
    else if (run)       div_q <= div_q + 1'b1;
  end

  assign tick = run && ((div_q & mask) == mask);

  // R4: above divide-by-1 two ticks never come back to back
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && exp != '0 && !restart) |=> (!tick || exp == '0));
endmodule

// File: rtl/gp_evtimer_core.sv
module gp_evtimer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic             down,
  input  logic             oneshot,
  input  logic [CNT_W-1:0] reload,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_ev,
  output logic             unf_ev
);
  always_comb begin
    ovf_ev = tick && !down && (cnt == reload);
    unf_ev = tick &&  down && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= cnt_wdata;
    end else if (tick) begin
      if (down) cnt <= unf_ev ? reload : cnt - 1'b1;
      else      cnt <= ovf_ev ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               running <= 1'b0;
    else if (stop)                         running <= 1'b0;
    else if (start)                        running <= 1'b1;
    else if (oneshot && (ovf_ev || unf_ev)) running <= 1'b0;
  end

  assert_up_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !down && cnt == reload && !cnt_we) |=> (cnt == '0));
  assert_down_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && down && cnt == '0 && !cnt_we) |=> (cnt == $past(reload)));
  assert_oneshot_halt_R7: assert property (@(posedge clk) disable iff (rst)
    (oneshot && (ovf_ev || unf_ev) && !start) |=> !running);
  assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!running && !cnt_we) |=> $stable(cnt));
endmodule

// File: rtl/gp_evtimer_flags.sv
module gp_evtimer_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] hw_set,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          ien_we,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] ien,
  output logic          irq
);
  logic [NF-1:0] sw_set, sw_clr;

  always_comb begin
    sw_set = set_we ? wdata : '0;
    sw_clr = clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ien   <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~sw_clr) | sw_set | hw_set;
      if (ien_we) ien <= wdata;
      irq <= |(flags & ien);
    end
  end

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we && hw_set == '0) |=> ((flags & $past(wdata)) == '0));
endmodule

// File: rtl/gp_evtimer.sv
module gp_evtimer
  import gp_evtimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned EXP_W = 4;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              we_ctrl, we_cmd, we_ien, we_fset, we_fclr, we_reld, we_cnt;
  logic              start, stop, running, tick, ovf_ev, unf_ev;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_FLAGS-1:0] flags, ien, hw_set;

  always_comb begin
    we_ctrl = bus_wr && bus_addr == ADDR_W'(OFS_CTRL);
    we_cmd  = bus_wr && bus_addr == ADDR_W'(OFS_CMD);
    we_ien  = bus_wr && bus_addr == ADDR_W'(OFS_IEN);
    we_fset = bus_wr && bus_addr == ADDR_W'(OFS_FSET);
    we_fclr = bus_wr && bus_addr == ADDR_W'(OFS_FCLR);
    we_reld = bus_wr && bus_addr == ADDR_W'(OFS_RELD);
    we_cnt  = bus_wr && bus_addr == ADDR_W'(OFS_COUNT);
    start   = we_cmd && bus_wdata[0];
    stop    = we_cmd && bus_wdata[1];
    hw_set  = '0;
    hw_set[FLAG_OVF] = ovf_ev;
    hw_set[FLAG_UNF] = unf_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '1;
    end else begin
      if (we_ctrl) ctrl_q <= '{exp: bus_wdata[27:24], src: bus_wdata[17:16],
                               oneshot: bus_wdata[4], mode: bus_wdata[1:0]};
      if (we_reld) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  gp_evtimer_presc #(.EXP_W(EXP_W)) u_presc (
    .clk(clk), .rst(rst),
    .run(running && ctrl_q.src == 2'd0),
    .restart(start), .exp(ctrl_q.exp), .tick(tick)
  );

  gp_evtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .tick(tick),
    .down(ctrl_q.mode[0]), .oneshot(ctrl_q.oneshot), .reload(reload_q),
    .cnt_we(we_cnt), .cnt_wdata(bus_wdata[CNT_W-1:0]),
    .running(running), .cnt(cnt), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  gp_evtimer_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .set_we(we_fset),
    .clr_we(we_fclr), .ien_we(we_ien), .wdata(bus_wdata[NUM_FLAGS-1:0]),
    .flags(flags), .ien(ien), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(OFS_CTRL): begin
          bus_rdata[27:24] <= ctrl_q.exp;
          bus_rdata[17:16] <= ctrl_q.src;
          bus_rdata[4]     <= ctrl_q.oneshot;
          bus_rdata[1:0]   <= ctrl_q.mode;
        end
        ADDR_W'(OFS_IEN):   bus_rdata[NUM_FLAGS-1:0] <= ien;
        ADDR_W'(OFS_FLAGS): bus_rdata[NUM_FLAGS-1:0] <= flags;
        ADDR_W'(OFS_RELD):  bus_rdata[CNT_W-1:0] <= reload_q;
        ADDR_W'(OFS_COUNT): bus_rdata[CNT_W-1:0] <= cnt;
        default: ;
      endcase
    end
  end

  // R3: a command word carrying both bits leaves the timer stopped
  assert_stop_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (start && stop) |=> !running);
endmodule

// File: tb/gp_evtimer_bench.sv
module gp_evtimer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gp_evtimer u_gp_evtimer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h1C, v); chk("R1 reload", v, 32'h0000FFFF);
    rd(8'h24, v); chk("R1 count", v, 32'h0);
    rd(8'h10, v); chk("R1 flags", v, 32'h0);
    rd(8'h0C, v); chk("R1 enable", v, 32'h0);

    // R2 field masks and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 ctrl mask", v, 32'h0F03_0013);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R2 enable mask", v, 32'h3);
    rd(8'h04, v); chk("R2 cmd reads 0", v, 32'h0);
    rd(8'h08, v); chk("R2 unmapped", v, 32'h0);
    wr(8'h0C, 32'h0);

    // R8 count write while stopped
    wr(8'h00, 32'h0);
    wr(8'h24, 32'h1234); rd(8'h24, v); chk("R8 count load", v, 32'h1234);
    idle(5); rd(8'h24, v); chk("R8 stopped hold", v, 32'h1234);

    // R3 stop wins over start
    wr(8'h04, 32'h3); idle(10); rd(8'h24, v); chk("R3 both bits stay stopped", v, 32'h1234);

    // R12 nonzero clock source
    wr(8'h00, 32'h0001_0000); wr(8'h04, 32'h1); idle(10); wr(8'h04, 32'h2);
    rd(8'h24, v); chk("R12 no advance", v, 32'h1234);

    // R4 R5 R6 sweep over prescale, direction and stop point
    wr(8'h1C, 32'd5);
    for (int p = 0; p < 4; p++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int wi = 0; wi < 6; wi++) begin
          int w, ticks, c;
          logic [1:0] fl;
          w = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? 2 : (wi == 3) ? 5 : (wi == 4) ? 9 : 14;
          c = dn ? 2 : 3;
          fl = 2'b00;
          wr(8'h00, (32'(p) << 24) | 32'(dn));
          wr(8'h24, 32'(c));
          wr(8'h18, 32'h3);
          wr(8'h04, 32'h1);
          idle(w);
          wr(8'h04, 32'h2);
          ticks = (1 + w) >> p;
          for (int k = 0; k < ticks; k++) begin
            if (dn == 0) begin
              if (c == 5) begin c = 0; fl[0] = 1'b1; end else c = c + 1;
            end else begin
              if (c == 0) begin c = 5; fl[1] = 1'b1; end else c = c - 1;
            end
          end
          rd(8'h24, v); chk(dn ? "R6 down count (R4 pace)" : "R5 up count (R4 pace)", v, 32'(c));
          rd(8'h10, v); chk(dn ? "R6 underflow flag" : "R5 overflow flag", v, {30'd0, fl});
        end
      end
    end

    // R4 start restarts prescale phase
    wr(8'h00, 32'h0200_0000); wr(8'h1C, 32'hFFFF); wr(8'h24, 32'h0);
    wr(8'h04, 32'h1); idle(1); wr(8'h04, 32'h1); idle(2); wr(8'h04, 32'h2);
    rd(8'h24, v); chk("R4 restart phase", v, 32'h0);

    // R7 one-shot down and up
    wr(8'h1C, 32'd5);
    wr(8'h00, 32'h11); wr(8'h24, 32'd3); wr(8'h18, 32'h3); wr(8'h04, 32'h1);
    idle(10); rd(8'h24, v); chk("R7 down one-shot count", v, 32'd5);
    idle(10); rd(8'h24, v); chk("R7 down one-shot halted", v, 32'd5);
    rd(8'h10, v); chk("R7 down flag", v, 32'h2);
    wr(8'h00, 32'h10); wr(8'h24, 32'd3); wr(8'h18, 32'h3); wr(8'h04, 32'h1);
    idle(10); rd(8'h24, v); chk("R7 up one-shot count", v, 32'd0);
    rd(8'h10, v); chk("R7 up flag", v, 32'h1);

    // R9 set, clear, and hardware event racing a clear
    wr(8'h18, 32'h3); wr(8'h14, 32'h2); rd(8'h10, v); chk("R9 set", v, 32'h2);
    wr(8'h18, 32'h2); rd(8'h10, v); chk("R9 clear", v, 32'h0);
    wr(8'h00, 32'h1); wr(8'h24, 32'd1);
    wr(8'h04, 32'h1); wr(8'h18, 32'h2); wr(8'h18, 32'h2); wr(8'h04, 32'h2);
    rd(8'h10, v); chk("R9 event beats clear", v, 32'h2);

    // R10 writes to flags offset ignored
    wr(8'h10, 32'h0); rd(8'h10, v); chk("R10 no clear via flags", v, 32'h2);
    wr(8'h18, 32'h3); wr(8'h10, 32'h3); rd(8'h10, v); chk("R10 no set via flags", v, 32'h0);

    // R11 interrupt
    wr(8'h0C, 32'h2); wr(8'h14, 32'h2);
    chk("R11 lag one clock", {31'd0, irq}, 32'd0);
    idle(1); chk("R11 asserted", {31'd0, irq}, 32'd1);
    idle(5); chk("R11 held", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h2); idle(1); chk("R11 cleared", {31'd0, irq}, 32'd0);
    wr(8'h0C, 32'h0); wr(8'h14, 32'h1); idle(2);
    chk("R11 disabled flag", {31'd0, irq}, 32'd0);
    wr(8'h0C, 32'h1); idle(2); chk("R11 enable existing flag", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule